// File: doc/BRIEF.md
# Dual-I/O Serial Port Mode Controller

This block sits between the two pins of a serial memory port and the slave engine that decodes commands. It moves bits one per serial clock over a single input pin in the default single-bit mode, or two per serial clock over two shared bidirectional pins in dual mode. It turns them into whole bytes for the engine, and turns the engine's read bytes back into pin values. It drives the output enables of both pins. On a dual-mode read it puts one dummy byte on the pins before any read data.

The block watches the first byte of each chip-select frame. A frame that opens with 0x3B while the port is in single-bit mode moves the port to dual mode. A frame that opens with 0xFF, sent in the current mode, moves it back to single-bit mode. The mode flag is kept outside the per-frame state, so it holds across frames.

The block runs on a fast system clock. Each serial clock edge on which data is sampled reaches it as a one-cycle `tick_i` strobe.

Top module: `sdi_port`

## Requirements
- R1: After reset, `dual_o` is 0, `sio_oe_o` is 2'b00, and `rx_valid_o` and `tx_req_o` are 0.
- R2: In single-bit mode, each tick while `cs_ni` is low shifts `sio_i[0]` into the receive byte, MSB first. On the 8th tick, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`. `rx_first_o` is 1 only for the first byte of the frame.
- R3: In dual mode, each tick shifts the pair {`sio_i[1]`,`sio_i[0]`} in, with `sio_i[1]` as the more significant bit and the first pair forming bits 7:6. A byte completes after 4 ticks.
- R4: A first byte of 0x3B received in single-bit mode sets `dual_o`. 0x3B received as a later byte of a frame, or received while in dual mode, leaves the mode unchanged.
- R5: A first byte of 0xFF clears `dual_o` in either mode. In dual mode this takes 4 ticks with both pins high.
- R6: The mode flag is unchanged by `cs_ni` going high and stays in force for later frames.
- R7: In single-bit mode, a `rd_go_i` pulse while selected loads `tx_byte_i`. The block then drives `sio_o[1]` MSB first with `sio_oe_o`=2'b10 and pulses `tx_req_o` for each byte it takes. Each tick advances one bit.
- R8: In dual mode, a `rd_go_i` pulse first puts a dummy byte of 0x00 on the pins for 4 ticks, with `sio_oe_o`=2'b11 and no `tx_req_o`. The block then takes `tx_byte_i` and drives `sio_o` with bits 7:6 first, advancing one pair per tick.
- R9: Reads stream whole bytes back to back, taking a new `tx_byte_i` after each completed byte, until `cs_ni` rises. The cycle after `cs_ni` is high, `sio_oe_o` is 2'b00.
- R10: Outside the read phase, both pins stay inputs (`sio_oe_o`=2'b00), including while a dual-mode command and address are being received.
- R11: If the tick that completes a first byte is followed at once by `cs_ni` rising, the mode command in that byte still takes effect. A tick in a cycle where `cs_ni` is already high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| tick_i | input | 1 | One-cycle strobe per serial clock sample point |
| sio_i | input | 2 | Pin input values: bit 0 is the data input pin, bit 1 is the data output pin |
| sio_o | output | 2 | Pin drive values |
| sio_oe_o | output | 2 | Per-pin output enable |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_byte_o` holds a new byte |
| rx_first_o | output | 1 | The byte on `rx_byte_o` is the first of its frame |
| rd_go_i | input | 1 | Pulse from the engine: start the read data phase |
| tx_byte_i | input | 8 | Next read byte from the engine |
| tx_req_o | output | 1 | One-cycle pulse when `tx_byte_i` has been taken |
| dual_o | output | 1 | Current port mode: 1 means dual |

## Verification
Two events can land on the same clock edge. The registered byte-complete pulse that carries a mode command can arrive in the same cycle as the chip-select rise that clears all per-frame state. The bench provokes this by raising `cs_ni` on the very next cycle after the final tick of a 0xFF frame sent in dual mode. It then reads `dual_o` to judge whether the command survived the frame teardown. Separately, read streams in both modes are rebuilt bit by bit from the pins and compared against the bytes offered, with the dummy byte counted in dual mode.

// File: rtl/sdi_pkg.sv
package sdi_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] OPC_DUAL_ON  = 8'h3B;
  localparam logic [7:0] OPC_DUAL_OFF = 8'hFF;
endpackage

// File: rtl/sdi_rx.sv
module sdi_rx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          tick_i,
  input  logic          hold_i,
  input  logic          dual_i,
  input  logic [1:0]    sio_i,
  output logic [DW-1:0] byte_o,
  output logic          valid_o,
  output logic          first_o
);
  localparam int CW = $clog2(DW) + 1;

  logic [DW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          first_q, wrap;

  always_comb begin
    sh_d  = dual_i ? {sh_q[DW-3:0], sio_i} : {sh_q[DW-2:0], sio_i[0]};
    cnt_d = cnt_q + (dual_i ? CW'(2) : CW'(1));
    wrap  = (cnt_d >= CW'(DW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0; cnt_q <= '0; first_q <= 1'b1;
      byte_o <= '0; valid_o <= 1'b0; first_o <= 1'b0;
    end else if (cs_ni) begin
      cnt_q <= '0; first_q <= 1'b1; valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick_i && !hold_i) begin
        sh_q <= sh_d;
        if (wrap) begin
          cnt_q   <= '0;
          byte_o  <= sh_d;
          valid_o <= 1'b1;
          first_o <= first_q;
          first_q <= 1'b0;
        end else begin
          cnt_q <= cnt_d;
        end
      end
    end
  end

  // R2: a byte needs several ticks, so completion is always a single-cycle pulse
  assert_rx_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R11: a tick while deselected never completes a byte
  assert_rx_desel_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !valid_o);
endmodule

// File: rtl/sdi_mode_ctl.sv
module sdi_mode_ctl
  import sdi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          first_i,
  input  logic [DW-1:0] byte_i,
  output logic          dual_o
);
  logic dual_q;

  // No chip-select term: the flag is frame-independent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dual_q <= 1'b0;
    else if (valid_i && first_i) begin
      if (!dual_q && byte_i == DW'(OPC_DUAL_ON)) dual_q <= 1'b1;
      else if (byte_i == DW'(OPC_DUAL_OFF))     dual_q <= 1'b0;
    end
  end

  assign dual_o = dual_q;

  // R4 / R5 / R6: mode moves only right after a completed first byte
  assert_mode_src_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dual_q != $past(dual_q)) |-> $past(valid_i && first_i));
endmodule

// File: rtl/sdi_tx.sv
module sdi_tx #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          tick_i,
  input  logic          go_i,
  input  logic          dual_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic [1:0]    sio_o,
  output logic [1:0]    oe_o,
  output logic          req_o,
  output logic          busy_o
);
  localparam int CW = $clog2(DW) + 1;

  logic          act_q, req_q;
  logic [DW-1:0] out_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  always_comb begin
    cnt_d = cnt_q + (dual_i ? CW'(2) : CW'(1));
    wrap  = (cnt_d >= CW'(DW));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0; req_q <= 1'b0; out_q <= '0; cnt_q <= '0;
    end else if (cs_ni) begin
      act_q <= 1'b0; req_q <= 1'b0; cnt_q <= '0;
    end else begin
      req_q <= 1'b0;
      if (go_i && !act_q) begin
        act_q <= 1'b1;
        cnt_q <= '0;
        if (dual_i) out_q <= '0;  // dummy byte, engine byte waits
        else begin
          out_q <= tx_byte_i;
          req_q <= 1'b1;
        end
      end else if (act_q && tick_i) begin
        if (wrap) begin
          out_q <= tx_byte_i;
          req_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          out_q <= dual_i ? (out_q << 2) : (out_q << 1);
          cnt_q <= cnt_d;
        end
      end
    end
  end

  always_comb begin
    sio_o = dual_i ? out_q[DW-1:DW-2] : {out_q[DW-1], 1'b0};
    if (!act_q)      oe_o = 2'b00;
    else if (dual_i) oe_o = 2'b11;
    else             oe_o = 2'b10;
  end

  assign req_o  = req_q;
  assign busy_o = act_q;

  // R9: pins released the cycle after deselect
  assert_oe_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (oe_o == 2'b00));
  // R7: each byte is taken exactly once
  assert_req_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  // R10: drive only while selected in the previous cycle
  assert_oe_sel_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o != 2'b00) |-> $past(!cs_ni));
endmodule

// File: rtl/sdi_port.sv
module sdi_port
  import sdi_pkg::*;
#(
  parameter int DW = BYTE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          tick_i,
  input  logic [1:0]    sio_i,
  output logic [1:0]    sio_o,
  output logic [1:0]    sio_oe_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          rx_valid_o,
  output logic          rx_first_o,
  input  logic          rd_go_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          tx_req_o,
  output logic          dual_o
);
  logic dual, busy;

  sdi_mode_ctl #(.DW(DW)) u_mode (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(rx_valid_o),
    .first_i(rx_first_o), .byte_i(rx_byte_o), .dual_o(dual)
  );

  sdi_rx #(.DW(DW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .tick_i(tick_i),
    .hold_i(busy), .dual_i(dual), .sio_i(sio_i), .byte_o(rx_byte_o),
    .valid_o(rx_valid_o), .first_o(rx_first_o)
  );

  sdi_tx #(.DW(DW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .tick_i(tick_i),
    .go_i(rd_go_i), .dual_i(dual), .tx_byte_i(tx_byte_i), .sio_o(sio_o),
    .oe_o(sio_oe_o), .req_o(tx_req_o), .busy_o(busy)
  );

  assign dual_o = dual;

  // R8: dual-mode read drives both pins, single-bit read drives only pin 1
  assert_oe_shape_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sio_oe_o != 2'b00) |-> (sio_oe_o == (dual ? 2'b11 : 2'b10)));
endmodule

// File: tb/sim_sdi_port.sv
`timescale 1ns/1ps
module sim_sdi_port;
  logic clk = 1'b0, rst_ni = 1'b0, cs_ni = 1'b1, tick_i = 1'b0, rd_go_i = 1'b0;
  logic [1:0] sio_i = 2'b00;
  logic [7:0] tx_byte_i = 8'h00;
  logic [1:0] sio_o, sio_oe_o;
  logic [7:0] rx_byte_o;
  logic rx_valid_o, rx_first_o, tx_req_o, dual_o;

  int n_run = 0, n_fail = 0;
  logic done = 1'b0;
  logic cap_v, cap_f, cap_r;
  logic [7:0] cap_b;

  always #2.5 clk = ~clk;

  sdi_port u0 (.clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .tick_i(tick_i),
    .sio_i(sio_i), .sio_o(sio_o), .sio_oe_o(sio_oe_o), .rx_byte_o(rx_byte_o),
    .rx_valid_o(rx_valid_o), .rx_first_o(rx_first_o), .rd_go_i(rd_go_i),
    .tx_byte_i(tx_byte_i), .tx_req_o(tx_req_o), .dual_o(dual_o));

  // {dual, byte}: receive vectors
  localparam logic [8:0] RX_VEC [6] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h03}, {1'b0, 8'h80},
    {1'b1, 8'h5A}, {1'b1, 8'hC3}, {1'b1, 8'h01}};

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] p, input int gap);
    @(negedge clk); sio_i = p; tick_i = 1'b1;
    @(negedge clk); tick_i = 1'b0;
    cap_v = rx_valid_o; cap_b = rx_byte_o; cap_f = rx_first_o; cap_r = tx_req_o;
    repeat (gap) @(negedge clk);
  endtask

  task automatic cs_lo(); @(negedge clk); cs_ni = 1'b0; endtask
  task automatic cs_hi(); @(negedge clk); cs_ni = 1'b1; @(negedge clk); endtask

  // shifts one byte in the given mode; quick leaves no gap after the last tick
  task automatic send(input logic [7:0] b, input logic dm, input logic quick);
    int steps;
    steps = dm ? 4 : 8;
    for (int k = 0; k < steps; k++) begin
      logic [1:0] p;
      p = dm ? b[7-2*k -: 2] : {1'b0, b[7-k]};
      tick(p, (quick && k == steps-1) ? 0 : 2);
      check(sio_oe_o == 2'b00, "R10", sio_oe_o, 0);
    end
  endtask

  task automatic frame(input logic [7:0] b, input logic dm);
    cs_lo(); send(b, dm, 1'b0); cs_hi();
  endtask

  function automatic logic [7:0] bval(input int i);
    return 8'(8'h3C + i * 8'h51);
  endfunction

  task automatic rd_stream(input logic dm, input int nb);
    cs_lo();
    send(8'h03, dm, 1'b0);
    tx_byte_i = bval(0);
    @(negedge clk); rd_go_i = 1'b1;
    @(negedge clk); rd_go_i = 1'b0;
    if (dm) begin
      check(sio_oe_o == 2'b11 && sio_o == 2'b00, "R8", {sio_oe_o, sio_o}, 4'b1100);
      check(tx_req_o == 1'b0, "R8", tx_req_o, 0);
      for (int k = 0; k < 4; k++) begin
        tick(2'b00, 2);
        if (k < 3) check(sio_o == 2'b00 && !cap_r, "R8", {cap_r, sio_o}, 0);
      end
      check(cap_r == 1'b1, "R8", cap_r, 1);
    end else begin
      check(sio_oe_o == 2'b10 && tx_req_o, "R7", {tx_req_o, sio_oe_o}, 3'b110);
    end
    for (int i = 0; i < nb; i++) begin
      logic [7:0] got;
      got = 8'h00;
      tx_byte_i = bval(i + 1);
      for (int s = 0; s < (dm ? 4 : 8); s++) begin
        got = dm ? {got[5:0], sio_o} : {got[6:0], sio_o[1]};
        tick(2'b00, 2);
      end
      check(got == bval(i), dm ? "R8" : "R7", got, bval(i));
      check(cap_r == 1'b1, "R9", cap_r, 1);
    end
    cs_hi();
    check(sio_oe_o == 2'b00, "R9", sio_oe_o, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(dual_o == 1'b0 && sio_oe_o == 2'b00, "R1", {dual_o, sio_oe_o}, 0);
    check(!rx_valid_o && !tx_req_o, "R1", {rx_valid_o, tx_req_o}, 0);

    // table walk: R2 / R3, with mode switching between groups (R4, R6)
    for (int v = 0; v < 6; v++) begin
      if (dual_o != RX_VEC[v][8]) begin
        frame(RX_VEC[v][8] ? 8'h3B : 8'hFF, dual_o);
        check(dual_o == RX_VEC[v][8], "R4", dual_o, RX_VEC[v][8]);
      end
      cs_lo(); send(RX_VEC[v][7:0], RX_VEC[v][8], 1'b0);
      check(cap_v && cap_b == RX_VEC[v][7:0] && cap_f,
            RX_VEC[v][8] ? "R3" : "R2", {cap_v, cap_f, cap_b}, {2'b11, RX_VEC[v][7:0]});
      cs_hi();
      check(dual_o == RX_VEC[v][8], "R6", dual_o, RX_VEC[v][8]);
    end

    // 0x3B while dual: no change
    frame(8'h3B, 1'b1);
    check(dual_o == 1'b1, "R4", dual_o, 1);
    // dual read stream with dummy byte
    rd_stream(1'b1, 3);
    // exit in dual: 4 ticks of 11, cs raised right after the last tick
    cs_lo(); send(8'hFF, 1'b1, 1'b1); cs_ni = 1'b1;
    repeat (2) @(negedge clk);
    check(dual_o == 1'b0, "R11", dual_o, 0);
    check(dual_o == 1'b0, "R5", dual_o, 0);

    // 0x3B as second byte: ignored, second byte not flagged first
    cs_lo(); send(8'h00, 1'b0, 1'b0); send(8'h3B, 1'b0, 1'b0);
    check(cap_v && !cap_f && cap_b == 8'h3B, "R2", {cap_v, cap_f, cap_b}, {2'b10, 8'h3B});
    cs_hi();
    check(dual_o == 1'b0, "R4", dual_o, 0);
    // 0xFF in single-bit mode keeps single-bit mode
    frame(8'hFF, 1'b0);
    check(dual_o == 1'b0, "R5", dual_o, 0);
    // single-bit read stream
    rd_stream(1'b0, 3);

    // tick while deselected is ignored
    frame(8'h3B, 1'b0);
    check(dual_o == 1'b1, "R4", dual_o, 1);
    tick(2'b11, 2); tick(2'b11, 2); tick(2'b11, 2); tick(2'b11, 2);
    check(!cap_v && dual_o == 1'b1, "R11", {cap_v, dual_o}, 2'b01);
    cs_lo(); send(8'h96, 1'b1, 1'b0);
    check(cap_v && cap_b == 8'h96 && cap_f, "R3", cap_b, 8'h96);
    cs_hi();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule